// File: doc/BRIEF.md
# Radix-B Sign-Magnitude Adder-Subtractor

This block adds or subtracts two signed numbers held in sign-magnitude form, where every digit is a small binary field holding a value in base RADIX. Each operand has NDIG-1 magnitude digits and one sign bit. The result has an NDIG-digit magnitude, one digit wider than the operands so it cannot overflow, and one sign bit. A single control input chooses the operation. Subtraction is done by inverting the sign of the second operand before it enters the datapath.

The datapath is purely combinational and has two ripple stages. The first stage handles the magnitudes. If the effective signs agree, it adds them. If they disagree, it adds the first magnitude to the digit-wise (RADIX-1) complement of the second, with a carry-in of one and a top extension digit of RADIX-1. This gives an intermediate value in radix complement form. The second stage looks at the top digit of that value. If the digit is at least RADIX/2, the value is negative: the stage complements it, adds one, and takes the sign from the second operand. Otherwise it passes the value through and takes the sign from the first operand.

Top module: `sm_addsub`

## Requirements
- R1: Every digit is a binary field of $clog2(RADIX) bits, holding a value from 0 to RADIX-1. Digit i occupies bits [i*DW +: DW], with the least significant digit at bit 0. Every output digit stays below RADIX.
- R2: With `op_sub`=0 the result is x+y. With `op_sub`=1 it is x-y. The effective sign of y is `y_sign` XOR `op_sub`. A sign bit of 1 means negative.
- R3: When `x_sign` equals the effective sign of y, `z_mag` equals the sum of the magnitudes and `z_sign` equals `x_sign`. The top result digit is then 0 or 1.
- R4: When the effective signs differ and |x| > |y|, `z_mag` is |x|-|y| and `z_sign` is `x_sign`.
- R5: When the effective signs differ and |x| < |y|, `z_mag` is |y|-|x| and `z_sign` is the effective sign of y. Recovering the magnitude never carries out of the top digit.
- R6: When the effective signs differ and |x| equals |y|, `z_mag` is zero and `z_sign` is `x_sign`. Whenever `z_mag` is zero, `z_sign` equals `x_sign`.
- R7: Operands whose magnitude digits are all RADIX-1 give exact results in every sign and operation combination. This includes the largest sum, 2*(RADIX^(NDIG-1)-1).
- R8: When the effective signs differ, the top result digit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_mag | input | (NDIG-1)*DW | Magnitude digits of the first operand |
| x_sign | input | 1 | Sign of the first operand (1 = negative) |
| y_mag | input | (NDIG-1)*DW | Magnitude digits of the second operand |
| y_sign | input | 1 | Sign of the second operand (1 = negative) |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| z_mag | output | NDIG*DW | Result magnitude digits |
| z_sign | output | 1 | Result sign |

## Verification
The bench drives every combination of two-digit decimal magnitudes, signs and operation, and compares each result against integer arithmetic.

It targets four kinds of corner case:
- **Equal magnitudes with opposite effective signs.** A design that picked the sign from the wrong operand, or misjudged the comparator threshold, would report a negative zero here.
- **Magnitudes one apart across the sign boundary.** A second stage that dropped its increment would be off by one exactly where the intermediate value turns negative.
- **All-nines operands.** These exercise the longest carry ripple and the top extension digit. A wrong extension digit or carry would corrupt the top result digit.
- **Subtract paired with negative y.** This confirms the sign flip is an XOR and not a plain overwrite.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;
  // Bits needed to hold one digit of the given radix.
  function automatic int digit_bits(input int radix);
    return (radix <= 2) ? 1 : $clog2(radix);
  endfunction
endpackage

// File: rtl/sm_digit_inv.sv
module sm_digit_inv #(
  parameter int RADIX = 10,
  parameter int NUM   = 4,
  localparam int DW   = sm_addsub_pkg::digit_bits(RADIX)
) (
  input  logic [NUM*DW-1:0] din,
  output logic [NUM*DW-1:0] dout
);
  localparam logic [DW-1:0] TOP_DIGIT = DW'(RADIX - 1);

  // Per-digit (RADIX-1)'s complement.
  for (genvar g = 0; g < NUM; g++) begin : g_dig
    assign dout[g*DW +: DW] = TOP_DIGIT - din[g*DW +: DW];
  end
endmodule

// File: rtl/sm_digit_ripple.sv
module sm_digit_ripple #(
  parameter int RADIX = 10,
  parameter int NUM   = 4,
  localparam int DW   = sm_addsub_pkg::digit_bits(RADIX)
) (
  input  logic [NUM*DW-1:0] a,
  input  logic [NUM*DW-1:0] b,
  input  logic              cin,
  output logic [NUM*DW-1:0] sum,
  output logic              cout
);
  localparam logic [DW:0] BASE = (DW+1)'(RADIX);

  logic [NUM:0] carry;
  assign carry[0] = cin;

  for (genvar g = 0; g < NUM; g++) begin : g_dig
    logic [DW:0] raw;
    logic        wrap;
    logic [DW:0] adj;
    always_comb begin
      raw  = {1'b0, a[g*DW +: DW]} + {1'b0, b[g*DW +: DW]} + {{DW{1'b0}}, carry[g]};
      wrap = (raw >= BASE);
      adj  = wrap ? (raw - BASE) : raw;
    end
    assign sum[g*DW +: DW] = adj[DW-1:0];
    assign carry[g+1]      = wrap;
  end

  assign cout = carry[NUM];
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int RADIX = 10,
  parameter int NDIG  = 4,
  localparam int DW   = sm_addsub_pkg::digit_bits(RADIX),
  localparam int MW   = (NDIG-1)*DW,
  localparam int RW   = NDIG*DW
) (
  input  logic [MW-1:0] x_mag,
  input  logic          x_sign,
  input  logic [MW-1:0] y_mag,
  input  logic          y_sign,
  input  logic          op_sub,
  output logic [RW-1:0] z_mag,
  output logic          z_sign
);
  localparam logic [DW-1:0] TOP_DIGIT = DW'(RADIX - 1);
  localparam logic [DW-1:0] HALF      = DW'(RADIX / 2);

  // Effective sign of y and the stage-1 mode.
  logic eff_ysign;
  logic mixed;
  assign eff_ysign = y_sign ^ op_sub;
  assign mixed     = x_sign ^ eff_ysign;

  // Stage 1: add x and (y or its complement).
  logic [MW-1:0] y_cmp;
  logic [MW-1:0] op2;
  logic [MW-1:0] low_sum;
  logic          c1;
  logic [DW-1:0] top1;

  sm_digit_inv #(.RADIX(RADIX), .NUM(NDIG-1)) u_inv_y (
    .din  (y_mag),
    .dout (y_cmp)
  );

  assign op2 = mixed ? y_cmp : y_mag;

  sm_digit_ripple #(.RADIX(RADIX), .NUM(NDIG-1)) u_stage1 (
    .a    (x_mag),
    .b    (op2),
    .cin  (mixed),
    .sum  (low_sum),
    .cout (c1)
  );

  // Extension digit (0 or RADIX-1) plus the last carry, mod RADIX.
  always_comb begin
    if (mixed) top1 = c1 ? '0 : TOP_DIGIT;
    else       top1 = {{(DW-1){1'b0}}, c1};
  end

  logic [RW-1:0] inter;
  assign inter = {top1, low_sum};

  // Stage 2: recover the magnitude when the intermediate is negative.
  logic          neg;
  logic [RW-1:0] inter_cmp;
  logic [RW-1:0] op3;
  logic          stage2_cout;

  assign neg = (top1 >= HALF);

  sm_digit_inv #(.RADIX(RADIX), .NUM(NDIG)) u_inv_a (
    .din  (inter),
    .dout (inter_cmp)
  );

  assign op3 = neg ? inter_cmp : inter;

  sm_digit_ripple #(.RADIX(RADIX), .NUM(NDIG)) u_stage2 (
    .a    (op3),
    .b    ('0),
    .cin  (neg),
    .sum  (z_mag),
    .cout (stage2_cout)
  );

  assign z_sign = neg ? eff_ysign : x_sign;
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
  parameter int RADIX = 10,
  parameter int NDIG  = 4,
  localparam int DW   = sm_addsub_pkg::digit_bits(RADIX),
  localparam int MW   = (NDIG-1)*DW,
  localparam int RW   = NDIG*DW
) (
  input logic [MW-1:0] x_mag,
  input logic          x_sign,
  input logic [MW-1:0] y_mag,
  input logic          y_sign,
  input logic          op_sub,
  input logic [RW-1:0] z_mag,
  input logic          z_sign,
  input logic          wrap
);
  logic [DW-1:0] ztop;
  logic          same;
  assign ztop = z_mag[RW-1 -: DW];
  assign same = (x_sign == (y_sign ^ op_sub));

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      // R1
      digit_range_chk: assert (int'(z_mag[i*DW +: DW]) < RADIX)
        else $error("result digit %0d out of range", i);
    end
    // R3
    same_sign_chk: assert (!same || (z_sign == x_sign && ztop <= DW'(1)))
      else $error("same-sign result wrong sign or top digit");
    // R8
    diff_top_chk: assert (same || ztop == '0)
      else $error("mixed-sign result has nonzero top digit");
    // R6
    zero_sign_chk: assert (z_mag != '0 || z_sign == x_sign)
      else $error("zero result with wrong sign");
    // R5
    no_wrap_chk: assert (!wrap)
      else $error("magnitude recovery carried out");
  end
endmodule

bind sm_addsub sm_addsub_chk #(.RADIX(RADIX), .NDIG(NDIG)) u_chk (
  .x_mag  (x_mag),
  .x_sign (x_sign),
  .y_mag  (y_mag),
  .y_sign (y_sign),
  .op_sub (op_sub),
  .z_mag  (z_mag),
  .z_sign (z_sign),
  .wrap   (stage2_cout)
);

// File: tb/sim_sm_addsub.sv
module sim_sm_addsub;
  localparam int B  = 10;
  localparam int N  = 3;
  localparam int DW = 4;
  localparam int MW = (N-1)*DW;
  localparam int RW = N*DW;
  localparam int MAXM = B*B - 1;

  logic clk;
  logic [MW-1:0] x_mag, y_mag;
  logic x_sign, y_sign, op_sub;
  logic [RW-1:0] z_mag;
  logic z_sign;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  sm_addsub #(.RADIX(B), .NDIG(N)) u0 (
    .x_mag(x_mag), .x_sign(x_sign), .y_mag(y_mag), .y_sign(y_sign),
    .op_sub(op_sub), .z_mag(z_mag), .z_sign(z_sign)
  );

  function automatic logic [RW-1:0] enc(input int v);
    logic [RW-1:0] r = '0;
    int t = v;
    for (int i = 0; i < N; i++) begin
      r[i*DW +: DW] = DW'(t % B);
      t = t / B;
    end
    return r;
  endfunction

  task automatic apply(input int xm, input bit xs, input int ym, input bit ys,
                       input bit sub, input string tag);
    int sx, sy, r, em;
    bit es;
    logic [RW-1:0] xe, ye, exp_mag;
    bit dig_ok;
    @(posedge clk);
    #1;
    xe = enc(xm); ye = enc(ym);
    x_mag = xe[MW-1:0]; y_mag = ye[MW-1:0];
    x_sign = xs; y_sign = ys; op_sub = sub;
    #1;
    sx = xs ? -xm : xm;
    sy = ys ? -ym : ym;
    r  = sub ? sx - sy : sx + sy;
    em = (r < 0) ? -r : r;
    es = (r < 0) ? 1'b1 : ((r > 0) ? 1'b0 : xs);
    exp_mag = enc(em);
    vectors++;
    dig_ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (int'(z_mag[i*DW +: DW]) >= B) dig_ok = 1'b0;
    if (!dig_ok) begin
      fails++;
      $display("FAIL R1 digit range: actual=%h expected digits<%0d", z_mag, B);
    end
    if (z_mag !== exp_mag || z_sign !== es) begin
      fails++;
      $display("FAIL %s x=%0s%0d y=%0s%0d sub=%0b: actual=%0b/%h expected=%0b/%h",
               tag, xs ? "-" : "+", xm, ys ? "-" : "+", ym, sub,
               z_sign, z_mag, es, exp_mag);
    end
  endtask

  function automatic string classify(input int xm, input bit xs, input int ym,
                                     input bit ys, input bit sub);
    bit eys = ys ^ sub;
    if (xm == MAXM && ym == MAXM) return "R7 all-max";
    if (xs == eys) return "R3 R2 same-sign";
    if (xm > ym) return "R4 R2 x-larger";
    if (xm < ym) return "R5 R2 y-larger";
    return "R6 R2 equal";
  endfunction

  initial begin
    x_mag = '0; y_mag = '0; x_sign = 0; y_sign = 0; op_sub = 0;
    // Idle zero inputs give a positive zero (R6).
    apply(0, 0, 0, 0, 0, "R6 idle-zero");
    // Directed corners: R7 all-max, R6 equal, R5 one apart.
    apply(MAXM, 0, MAXM, 0, 0, "R7 max-sum");
    apply(MAXM, 1, MAXM, 0, 1, "R7 max-neg-sum");
    apply(MAXM, 0, MAXM, 0, 1, "R6 R7 max-equal");
    apply(0, 1, MAXM, 1, 1, "R5 R7 zero-minus-negmax");
    apply(50, 0, 51, 0, 1, "R5 one-apart");
    apply(51, 1, 50, 1, 0, "R3 neg-sum");
    // Exhaustive sweep (R1-tagged per check inside apply).
    for (int xm = 0; xm <= MAXM; xm++)
      for (int ym = 0; ym <= MAXM; ym++)
        for (int k = 0; k < 8; k++)
          apply(xm, k[2], ym, k[1], k[0],
                classify(xm, k[2], ym, k[1], k[0]));
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected=completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule